// File: doc/BRIEF.md
# Wide Register Value Plus Small Signed Offset Adder

This block adds a short two's-complement offset to a wide register value. It does not use a carry-propagate adder across the full width. The offset is sign-extended to a narrow low field, and only that field goes through a real adder. The upper bits of the result come from one of three copies of the operand's upper bits: the bits as they are, the bits plus one, or the bits minus one. A small decode of the low adder's carry-out and the offset's sign picks the copy.

The increment and decrement copies are built from prefix chains on the upper bits alone. They can therefore be formed at the same time as the low add. The only step left after the carry is known is the final three-way select. The result is captured in one register stage with a valid flag. It wraps modulo 2^DATA_W and has no overflow indication.

Top module: `wide_offset_adder`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `sum` equals `base` plus the sign-extended `offset`, modulo 2^DATA_W, and `out_valid` is high.
- R2: While `rst_n` is low at a clock edge, `out_valid` and `sum` both clear to zero at that edge.
- R3: The result wraps with no flag. All ones plus offset +1 gives zero, and zero plus offset -1 (offset bits 0x7FF) gives all ones.
- R4: `offset` is an OFF_W-bit two's-complement value, so the range is -1024 (bits 0x400) to +1023 (bits 0x3FF). Both extremes give the exact sum.
- R5: If the unsigned sum of the low LOW_W bits of `base` and the sign-extended offset does not carry out, and the offset is non-negative, then result bits [DATA_W-1:LOW_W] equal the matching bits of `base`. The same holds when the offset is negative and that sum does carry out.
- R6: If the offset is non-negative and the low sum carries out, the upper result bits are the upper bits of `base` plus one. This includes a carry that ripples through every upper bit when they are all ones.
- R7: If the offset is negative and the low sum does not carry out, the upper result bits are the upper bits of `base` minus one. This includes a borrow that ripples through every upper bit when they are all zeros.
- R8: An edge where `in_valid` is low leaves `sum` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture a new sum at this edge |
| base | input | DATA_W (64) | Wide register value |
| offset | input | OFF_W (11) | Signed two's-complement offset |
| out_valid | output | 1 | `sum` holds a result captured at the previous edge |
| sum | output | DATA_W (64) | Registered wrapped sum |

## Verification
The bench uses the default parameters: DATA_W=64, OFF_W=11 and LOW_W=11. This gives a 53-bit upper field. The directed cases can then drive the increment chain and the decrement chain through all 53 upper bits, and use both ends of the offset range. Random operands are biased so that the upper field is often all ones or all zeros. This makes the keep, increment and decrement selections all occur often, and each is checked against a plain full-width addition.

// File: rtl/wide_offset_adder_pkg.sv
// Package: shared types for the wide-value plus small-offset adder.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package wide_offset_adder_pkg;

    // Which copy of the upper bits forms the result
    typedef enum logic [1:0] {
        UPPER_KEEP = 2'd0,
        UPPER_INC  = 2'd1,
        UPPER_DEC  = 2'd2
    } upper_sel_e;

endpackage

// File: rtl/woa_low_adder.sv
// Module: woa_low_adder
// Narrow true adder on the low LOW_W bits. Sign-extends the OFF_W-bit offset
// to LOW_W bits, adds it as an unsigned pattern and returns the carry-out.
// Assumes LOW_W >= OFF_W.
module woa_low_adder #(
    parameter int LOW_W = 11,
    parameter int OFF_W = 11
) (
    input  logic [LOW_W-1:0] base_lo,
    input  logic [OFF_W-1:0] offset,
    output logic [LOW_W-1:0] low_sum,
    output logic             low_carry,
    output logic             off_neg
);

    logic [LOW_W-1:0] off_ext;

    // Pick the sign-extension form that suits the parameter pair
    generate
        if (LOW_W > OFF_W) begin : g_ext
            assign off_ext = {{(LOW_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_same
            assign off_ext = offset;
        end
    endgenerate

    // Narrow add with explicit carry-out
    always_comb begin
        {low_carry, low_sum} = {1'b0, base_lo} + {1'b0, off_ext};
        off_neg              = offset[OFF_W-1];
    end

endmodule

// File: rtl/woa_upper_step.sv
// Module: woa_upper_step
// Forms the upper field plus one and minus one with prefix chains. No adder
// is used: a bit flips on increment when all lower bits are one, and flips on
// decrement when all lower bits are zero. Assumes HI_W >= 1.
module woa_upper_step #(
    parameter int HI_W = 53
) (
    input  logic [HI_W-1:0] hi,
    output logic [HI_W-1:0] hi_inc,
    output logic [HI_W-1:0] hi_dec
);

    logic [HI_W-1:0] ones_below;
    logic [HI_W-1:0] zeros_below;

    assign ones_below[0]  = 1'b1;
    assign zeros_below[0] = 1'b1;

    // Prefix chains over the upper bits, one stage per bit
    generate
        for (genvar i = 1; i < HI_W; i++) begin : g_chain
            assign ones_below[i]  = ones_below[i-1]  &  hi[i-1];
            assign zeros_below[i] = zeros_below[i-1] & ~hi[i-1];
        end
    endgenerate

    // Toggle masks give the stepped copies
    always_comb begin
        hi_inc = hi ^ ones_below;
        hi_dec = hi ^ zeros_below;
    end

endmodule

// File: rtl/woa_upper_select.sv
// Module: woa_upper_select
// Decodes the low carry and the offset sign into a selection and muxes the
// upper copy. Positive with carry gives increment, negative without carry
// gives decrement, and anything else keeps the bits.
module woa_upper_select
    import wide_offset_adder_pkg::*;
#(
    parameter int HI_W = 53
) (
    input  logic            low_carry,
    input  logic            off_neg,
    input  logic [HI_W-1:0] hi,
    input  logic [HI_W-1:0] hi_inc,
    input  logic [HI_W-1:0] hi_dec,
    output logic [HI_W-1:0] hi_out
);

    upper_sel_e sel;

    // Selection decode from carry and sign
    always_comb begin
        if (low_carry && !off_neg)      sel = UPPER_INC;
        else if (!low_carry && off_neg) sel = UPPER_DEC;
        else                            sel = UPPER_KEEP;
    end

    // Three-way mux of the upper copies
    always_comb begin
        unique case (sel)
            UPPER_INC: hi_out = hi_inc;
            UPPER_DEC: hi_out = hi_dec;
            default:   hi_out = hi;
        endcase
    end

endmodule

// File: rtl/wide_offset_adder.sv
// Module: wide_offset_adder (top)
// Adds a signed OFF_W-bit offset to a DATA_W-bit value. A narrow low adder is
// combined with a carry-selected upper step, and the result goes through one
// register stage. The result wraps modulo 2^DATA_W.
// Assumes OFF_W <= LOW_W < DATA_W. Reset is synchronous and active low.
module wide_offset_adder #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 11,
    parameter int LOW_W  = OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] sum
);

    localparam int HI_W = DATA_W - LOW_W;

    logic [LOW_W-1:0] low_sum;
    logic             low_carry;
    logic             off_neg;
    logic [HI_W-1:0]  hi_inc;
    logic [HI_W-1:0]  hi_dec;
    logic [HI_W-1:0]  hi_out;

    woa_low_adder #(.LOW_W(LOW_W), .OFF_W(OFF_W)) u_low (
        .base_lo   (base[LOW_W-1:0]),
        .offset    (offset),
        .low_sum   (low_sum),
        .low_carry (low_carry),
        .off_neg   (off_neg)
    );

    woa_upper_step #(.HI_W(HI_W)) u_step (
        .hi     (base[DATA_W-1:LOW_W]),
        .hi_inc (hi_inc),
        .hi_dec (hi_dec)
    );

    woa_upper_select #(.HI_W(HI_W)) u_sel (
        .low_carry (low_carry),
        .off_neg   (off_neg),
        .hi        (base[DATA_W-1:LOW_W]),
        .hi_inc    (hi_inc),
        .hi_dec    (hi_dec),
        .hi_out    (hi_out)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) sum <= {hi_out, low_sum};
        end
    end

endmodule

// File: rtl/wide_offset_adder_checker.sv
// Module: wide_offset_adder_checker
// Port-level properties for wide_offset_adder. It is attached with bind.
module wide_offset_adder_checker #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 11,
    parameter int LOW_W  = OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] base,
    input logic [OFF_W-1:0]  offset,
    input logic              out_valid,
    input logic [DATA_W-1:0] sum
);

    localparam int HI_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] off_full;
    assign off_full = {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};

    // R1: registered result equals a plain full-width add of the last inputs
    assert_sum_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sum == $past(base) + $past(off_full));

    // R2: reset clears the outputs
    assert_reset_clears_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum == '0));

    // R3: all ones plus one wraps to zero
    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && base == '1 && offset == OFF_W'(1)) |=> sum == '0);

    // R6: non-negative offset never lowers the upper field
    assert_upper_nondec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !offset[OFF_W-1]) |=>
        (sum[DATA_W-1:LOW_W] == $past(base[DATA_W-1:LOW_W]) ||
         sum[DATA_W-1:LOW_W] == $past(base[DATA_W-1:LOW_W]) + HI_W'(1)));

    // R7: negative offset never raises the upper field
    assert_upper_noninc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && offset[OFF_W-1]) |=>
        (sum[DATA_W-1:LOW_W] == $past(base[DATA_W-1:LOW_W]) ||
         sum[DATA_W-1:LOW_W] == $past(base[DATA_W-1:LOW_W]) - HI_W'(1)));

    // R8: no capture when idle
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sum)));

endmodule

bind wide_offset_adder wide_offset_adder_checker #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .LOW_W(LOW_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .base      (base),
    .offset    (offset),
    .out_valid (out_valid),
    .sum       (sum)
);

// File: tb/wide_offset_adder_bench.sv
`timescale 1ns/1ps
module wide_offset_adder_bench;

    localparam int DATA_W = 64;
    localparam int OFF_W  = 11;
    localparam int LOW_W  = 11;
    localparam int HI_W   = DATA_W - LOW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] base = '0;
    logic [OFF_W-1:0]  offset = '0;
    logic              out_valid;
    logic [DATA_W-1:0] sum;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wide_offset_adder #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LOW_W(LOW_W)) u_wide_offset_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base(base),
        .offset(offset), .out_valid(out_valid), .sum(sum)
    );

    function automatic logic [DATA_W-1:0] ref_sum(logic [DATA_W-1:0] b, logic [OFF_W-1:0] o);
        return b + {{(DATA_W-OFF_W){o[OFF_W-1]}}, o};
    endfunction

    // Expected upper field from the requirement: carry from low field and sign
    function automatic logic [HI_W-1:0] ref_upper(logic [DATA_W-1:0] b, logic [OFF_W-1:0] o);
        int unsigned lo;
        lo = int'(b[LOW_W-1:0]) + int'(o);
        if (!o[OFF_W-1] && lo >= (1 << LOW_W)) return b[DATA_W-1:LOW_W] + HI_W'(1);
        if (o[OFF_W-1] && lo < (1 << LOW_W))   return b[DATA_W-1:LOW_W] - HI_W'(1);
        return b[DATA_W-1:LOW_W];
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one operand pair and check the result one edge later
    task automatic apply(string tag, logic [DATA_W-1:0] b, logic [OFF_W-1:0] o);
        @(negedge clk);
        in_valid = 1'b1; base = b; offset = o;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid", {63'd0, out_valid}, 64'd1);
        check(tag, sum, ref_sum(b, o));
        check("R5/R6/R7 upper", {{LOW_W{1'b0}}, sum[DATA_W-1:LOW_W]}, {{LOW_W{1'b0}}, ref_upper(b, o)});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        in_valid = 1'b1; base = '1; offset = 11'h3FF;
        @(negedge clk);
        // R2: reset state while reset held
        check("R2 out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 sum", sum, 64'd0);
        rst_n = 1'b1; in_valid = 1'b0;

        // R3: wrap both ways
        apply("R3 all ones +1", '1, 11'h001);
        apply("R3 zero -1", '0, 11'h7FF);
        // R4: range extremes
        apply("R4 -1024", 64'h0123_4567_89AB_CDEF, 11'h400);
        apply("R4 +1023", 64'h0123_4567_89AB_CDEF, 11'h3FF);
        apply("R4 -1024 small", 64'd100, 11'h400);
        // R5: keep cases
        apply("R5 no carry", 64'hDEAD_BEEF_0000_0010, 11'h005);
        apply("R5 neg with carry", 64'hDEAD_BEEF_0000_07FF, 11'h7FE);
        // R6: increment, full ripple of the upper field
        apply("R6 ripple", 64'hFFFF_FFFF_FFFF_F800 | 64'h7FF, 11'h001);
        apply("R6 ripple top", 64'h7FFF_FFFF_FFFF_FFFF, 11'h001);
        apply("R6 inc", 64'h0000_0000_0000_07F0, 11'h3FF);
        // R7: decrement, full borrow of the upper field
        apply("R7 borrow", 64'h8000_0000_0000_0000, 11'h7FF);
        apply("R7 dec", 64'h0000_1000_0000_0000, 11'h400);

        // R8: idle edge holds sum and drops valid
        held = sum;
        @(negedge clk);
        in_valid = 1'b0; base = 64'h5555_5555_5555_5555; offset = 11'h123;
        @(negedge clk);
        check("R8 out_valid", {63'd0, out_valid}, 64'd0);
        check("R8 sum held", sum, held);

        // R1: biased random operands
        for (int n = 0; n < 3000; n++) begin
            logic [DATA_W-1:0] b;
            logic [OFF_W-1:0]  o;
            b = {$urandom, $urandom};
            case ($urandom % 4)
                0: b[DATA_W-1:LOW_W] = '1;
                1: b[DATA_W-1:LOW_W] = '0;
                default: ;
            endcase
            o = OFF_W'($urandom);
            apply("R1 random", b, o);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule